// File: doc/BRIEF.md
# Digit-Serial Comba Carry-Less Multiplier

This block forms the full carry-less (GF(2)[x]) product of two N-bit binary polynomials held in external operand memories. Each operand is stored as D = N/BW words of BW bits, word d holding coefficient bits d·BW to d·BW+BW−1. After a start pulse the block walks the result columns in ascending order. For each column it reads every pair of operand digits whose indices add up to the column index, multiplies each pair in a combinational BW×BW carry-less core, and folds the product into a two-word accumulator.

When a column is complete, the low accumulator word is written to the result memory and the high word moves down to take its place. The running sum therefore never needs more than 2·BW bits, and every one of the 2·D result words is written exactly once, in address order. No modular reduction is performed. The operand memories answer a read address with data one cycle later. The result port is a plain address/data/enable write port, and a one-cycle done pulse closes each operation.

Top module: `clmul_comba`

## Requirements
- R1: After done, result word m (address m, 0 ≤ m < 2·D) equals bits m·BW to m·BW+BW−1 of the 2N-bit carry-less product of A and B. Operand data is sampled one cycle after its read address is presented.
- R2: Each operation asserts the result write enable exactly 2·D times. Addresses run 0, 1, …, 2·D−1, with no address repeated.
- R3: Each operation performs exactly D·D operand reads (cycles with the read strobe high), which is the same number of digit products as the schoolbook method.
- R4: Operand reads follow column order. While the read strobe stays high, the index sum (A address + B address) either holds, in which case the A address rises by one, or grows by exactly one. Both addresses stay below D.
- R5: done_o is high for exactly one cycle, and that cycle directly follows the cycle in which the last result word's write enable was high.
- R6: A start pulse that arrives while an operation is in progress is ignored. The running operation completes with unchanged results and write count.
- R7: While reset is applied and right after it, done_o, the read strobe and the result write enable are low.
- R8: The top result word (address 2·D−1) holds the carry left in the accumulator after the last column. Its most significant bit is always 0, because the product has at most 2N−1 significant bits.
- R9: Each accepted start clears the accumulator. A second operation issued right after the first gives the same result as it would from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| done_o | output | 1 | One-cycle pulse after the last result write |
| op_rd_o | output | 1 | Operand read strobe, one digit product per strobe |
| a_addr_o | output | AW | Digit address into operand A memory |
| a_data_i | input | BW | A digit, valid one cycle after its address |
| b_addr_o | output | AW | Digit address into operand B memory |
| b_data_i | input | BW | B digit, valid one cycle after its address |
| res_we_o | output | 1 | Result write enable |
| res_addr_o | output | RW | Result word address |
| res_data_o | output | BW | Result word data |

## Verification
All-ones operands fill every column with the largest possible number of set products. A wrong carry hand-off between the two accumulator words, or a missing clear of the high word after commit, would corrupt every middle word and leave a set bit in the top word's MSB. A single set bit at the top of both operands lands only in the last column and the extra leftover word, so a design that dropped the final flush word or wrote it early would miss it. A second start mid-operation, followed by back-to-back operations with zero operands, exposes a design that restarts its schedule or keeps stale accumulator contents. Random operands against a bit-serial reference catch off-by-one-cycle data alignment with the read latency.

// File: rtl/clmul_comba_pkg.sv
package clmul_comba_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_DRAIN,
    SEQ_FLUSH,
    SEQ_FIN
  } seq_state_e;
endpackage

// File: rtl/cl_digit_mul.sv
module cl_digit_mul #(
  parameter int BW = 64,
  localparam int PW = 2 * BW - 1
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  // shifted-row form: one XOR row per set bit of b
  always_comb begin
    p_o = '0;
    for (int j = 0; j < BW; j++) begin
      if (b_i[j]) p_o = p_o ^ (PW'(a_i) << j);
    end
  end
endmodule

// File: rtl/comba_sched.sv
module comba_sched
  import clmul_comba_pkg::*;
#(
  parameter int D  = 4,
  parameter int AW = 2,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          rd_en_o,
  output logic          last_o,
  output logic [AW-1:0] a_addr_o,
  output logic [AW-1:0] b_addr_o,
  output logic          flush_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST_COL = CW'(2 * D - 2);

  seq_state_e    state_q;
  logic [CW-1:0] col_q, idx_q;
  logic          done_q;

  function automatic logic [CW-1:0] col_lo(input logic [CW-1:0] c);
    return (c >= CW'(D)) ? c - CW'(D - 1) : '0;
  endfunction

  function automatic logic [CW-1:0] col_hi(input logic [CW-1:0] c);
    return (c < CW'(D)) ? c : CW'(D - 1);
  endfunction

  assign accept_o = (state_q == SEQ_IDLE) && start_i;
  assign rd_en_o  = (state_q == SEQ_RUN);
  assign last_o   = (idx_q == col_hi(col_q));
  assign a_addr_o = AW'(idx_q);
  assign b_addr_o = AW'(col_q - idx_q);
  assign flush_o  = (state_q == SEQ_FLUSH);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      col_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == SEQ_FIN);
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          col_q   <= '0;
          idx_q   <= '0;
          state_q <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (last_o) begin
            if (col_q == LAST_COL) begin
              state_q <= SEQ_DRAIN;
            end else begin
              col_q <= col_q + 1'b1;
              idx_q <= col_lo(col_q + 1'b1);
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SEQ_DRAIN: state_q <= SEQ_FLUSH;
        SEQ_FLUSH: state_q <= SEQ_FIN;
        SEQ_FIN:   state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/comba_acc.sv
module comba_acc #(
  parameter int BW = 64,
  parameter int RW = 3,
  localparam int PW = 2 * BW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic          last_i,
  input  logic          flush_i,
  input  logic [PW-1:0] prod_i,
  output logic          we_o,
  output logic [RW-1:0] addr_o,
  output logic [BW-1:0] data_o
);
  logic [BW-1:0] reg0_q, reg1_q;
  logic [RW-1:0] wptr_q;
  logic [BW-1:0] prod_lo, prod_hi;

  assign prod_lo = prod_i[BW-1:0];
  assign prod_hi = {1'b0, prod_i[PW-1:BW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg0_q <= '0;
      reg1_q <= '0;
      wptr_q <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (clr_i) begin
        reg0_q <= '0;
        reg1_q <= '0;
        wptr_q <= '0;
      end else if (vld_i) begin
        if (last_i) begin
          // commit column, shift carry down one digit
          we_o   <= 1'b1;
          addr_o <= wptr_q;
          data_o <= reg0_q ^ prod_lo;
          wptr_q <= wptr_q + 1'b1;
          reg0_q <= reg1_q ^ prod_hi;
          reg1_q <= '0;
        end else begin
          reg0_q <= reg0_q ^ prod_lo;
          reg1_q <= reg1_q ^ prod_hi;
        end
      end else if (flush_i) begin
        we_o   <= 1'b1;
        addr_o <= wptr_q;
        data_o <= reg0_q;
        wptr_q <= wptr_q + 1'b1;
        reg0_q <= '0;
      end
    end
  end
endmodule

// File: rtl/clmul_comba.sv
module clmul_comba #(
  parameter int N  = 256,
  parameter int BW = 64,
  localparam int D  = N / BW,
  localparam int AW = (D > 1) ? $clog2(D) : 1,
  localparam int RW = $clog2(2 * D),
  localparam int PW = 2 * BW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          op_rd_o,
  output logic [AW-1:0] a_addr_o,
  input  logic [BW-1:0] a_data_i,
  output logic [AW-1:0] b_addr_o,
  input  logic [BW-1:0] b_data_i,
  output logic          res_we_o,
  output logic [RW-1:0] res_addr_o,
  output logic [BW-1:0] res_data_o
);
  logic          accept, last, flush;
  logic          p_vld_q, p_last_q;
  logic [PW-1:0] prod;

  comba_sched #(.D(D), .AW(AW), .CW(RW)) sched_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .rd_en_o  (op_rd_o),
    .last_o   (last),
    .a_addr_o (a_addr_o),
    .b_addr_o (b_addr_o),
    .flush_o  (flush),
    .done_o   (done_o)
  );

  // align strobe with the one-cycle memory read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q  <= 1'b0;
      p_last_q <= 1'b0;
    end else begin
      p_vld_q  <= op_rd_o;
      p_last_q <= op_rd_o && last;
    end
  end

  cl_digit_mul #(.BW(BW)) mul_i (
    .a_i (a_data_i),
    .b_i (b_data_i),
    .p_o (prod)
  );

  comba_acc #(.BW(BW), .RW(RW)) acc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .vld_i   (p_vld_q),
    .last_i  (p_last_q),
    .flush_i (flush),
    .prod_i  (prod),
    .we_o    (res_we_o),
    .addr_o  (res_addr_o),
    .data_o  (res_data_o)
  );
endmodule

// File: rtl/clmul_comba_chk.sv
module clmul_comba_chk #(
  parameter int D  = 4,
  parameter int AW = 2,
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          op_rd_o,
  input logic [AW-1:0] a_addr_o,
  input logic [AW-1:0] b_addr_o,
  input logic          res_we_o,
  input logic [RW-1:0] res_addr_o
);
  logic [AW:0]   sum_now;
  logic [RW:0]   wr_cnt_q;
  logic [31:0]   rd_cnt_q;

  assign sum_now = {1'b0, a_addr_o} + {1'b0, b_addr_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
    end else if (done_o) begin
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
    end else begin
      wr_cnt_q <= wr_cnt_q + (RW+1)'(res_we_o);
      rd_cnt_q <= rd_cnt_q + 32'(op_rd_o);
    end
  end

  // R2
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> ({1'b0, res_addr_o} == wr_cnt_q));
  // R2
  wr_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_cnt_q == (RW+1)'(2 * D)));
  // R3
  rd_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_cnt_q == 32'(D * D)));
  // R4
  col_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_rd_o && $past(op_rd_o)) |->
      ((sum_now == $past(sum_now) && a_addr_o == $past(a_addr_o) + 1'b1) ||
       (sum_now == $past(sum_now) + 1'b1)));
  // R4
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_rd_o |-> (32'(a_addr_o) < D && 32'(b_addr_o) < D));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(res_we_o) && !res_we_o));
endmodule

bind clmul_comba clmul_comba_chk #(.D(D), .AW(AW), .RW(RW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .op_rd_o    (op_rd_o),
  .a_addr_o   (a_addr_o),
  .b_addr_o   (b_addr_o),
  .res_we_o   (res_we_o),
  .res_addr_o (res_addr_o)
);

// File: tb/clmul_comba_tb_top.sv
module clmul_comba_tb_top;
  localparam int N  = 320;
  localparam int BW = 64;
  localparam int D  = N / BW;
  localparam int NW = 2 * D;
  localparam int AW = $clog2(D);
  localparam int RW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, op_rd, res_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [BW-1:0] a_q, b_q, res_data;
  logic [RW-1:0] res_addr;

  logic [BW-1:0] a_mem [D];
  logic [BW-1:0] b_mem [D];
  logic [BW-1:0] r_mem [NW];
  int            wr_hits [NW];
  int            rd_cnt, done_cnt, bad_wr, ord_err, cyc, last_we_cyc, done_cyc;
  logic [AW:0]   prev_sum;
  logic [AW-1:0] prev_a;
  bit            have_prev;
  int            checks = 0, errors = 0;

  always #5 clk = ~clk;

  clmul_comba #(.N(N), .BW(BW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .done_o     (done),
    .op_rd_o    (op_rd),
    .a_addr_o   (a_addr),
    .a_data_i   (a_q),
    .b_addr_o   (b_addr),
    .b_data_i   (b_q),
    .res_we_o   (res_we),
    .res_addr_o (res_addr),
    .res_data_o (res_data)
  );

  // operand memories, one-cycle read latency
  always_ff @(posedge clk) begin
    a_q <= (32'(a_addr) < D) ? a_mem[a_addr] : '0;
    b_q <= (32'(b_addr) < D) ? b_mem[b_addr] : '0;
  end

  // port monitor, away from the active edge
  always @(negedge clk) begin
    logic [AW:0] s;
    cyc++;
    if (res_we) begin
      if (32'(res_addr) < NW) begin
        r_mem[res_addr] = res_data;
        wr_hits[res_addr]++;
      end else bad_wr++;
      last_we_cyc = cyc;
    end
    if (op_rd) begin
      rd_cnt++;
      s = {1'b0, a_addr} + {1'b0, b_addr};
      if (have_prev) begin
        if (s == prev_sum) begin
          if (a_addr != prev_a + 1'b1) ord_err++;
        end else if (s != prev_sum + 1'b1) ord_err++;
      end
      prev_sum  = s;
      prev_a    = a_addr;
      have_prev = 1'b1;
    end else have_prev = 1'b0;
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] p = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) p = p ^ ({{N{1'b0}}, a} << i);
    return p;
  endfunction

  function automatic logic [N-1:0] rand_op();
    logic [N-1:0] v;
    for (int k = 0; k < N / 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input string name, input bit mid_start);
    logic [2*N-1:0] exp_p;
    int             hit_err, t;
    for (int d = 0; d < D; d++) begin
      a_mem[d] = a[d*BW +: BW];
      b_mem[d] = b[d*BW +: BW];
    end
    for (int m = 0; m < NW; m++) begin
      r_mem[m] = 'x;
      wr_hits[m] = 0;
    end
    rd_cnt = 0; done_cnt = 0; bad_wr = 0; ord_err = 0;
    last_we_cyc = -100; done_cyc = -1;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    if (mid_start) begin
      repeat (6) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 2000) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    #2;
    if (t >= 2000) begin
      checks++; errors++;
      $display("FAIL R5 %s: no done, actual 0 expected 1", name);
      return;
    end
    exp_p = ref_mul(a, b);
    // R1 word-by-word against bit-serial reference
    for (int m = 0; m < NW; m++)
      check(r_mem[m] === exp_p[m*BW +: BW], "R1", $sformatf("%s word %0d", name, m),
            r_mem[m], exp_p[m*BW +: BW]);
    hit_err = bad_wr;
    for (int m = 0; m < NW; m++) if (wr_hits[m] != 1) hit_err++;
    // R2 every address written once
    check(hit_err == 0, "R2", {name, " write-once violations"}, BW'(hit_err), '0);
    // R3 digit product count
    check(rd_cnt == D * D, "R3", {name, " read count"}, BW'(rd_cnt), BW'(D * D));
    // R4 column ordering
    check(ord_err == 0, "R4", {name, " order errors"}, BW'(ord_err), '0);
    // R5 single done pulse right after last write
    check(done_cnt == 1, "R5", {name, " done cycles"}, BW'(done_cnt), BW'(1));
    check(done_cyc == last_we_cyc + 1, "R5", {name, " done position"},
          BW'(done_cyc - last_we_cyc), BW'(1));
    // R8 top word MSB always clear
    check(r_mem[NW-1][BW-1] === 1'b0, "R8", {name, " top word msb"},
          BW'(r_mem[NW-1][BW-1]), '0);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] top_bit;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2;
    // R7 outputs quiet during reset
    check(!done && !op_rd && !res_we, "R7", "in reset",
          BW'({done, op_rd, res_we}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !op_rd && !res_we, "R7", "after reset",
          BW'({done, op_rd, res_we}), '0);

    // R8 all-ones fills every column; top word holds the leftover carry
    run_op('1, '1, "all_ones", 1'b0);
    // R9 zeros right after all-ones: accumulator must be cleared
    run_op('0, '0, "zeros_after_ones", 1'b0);
    top_bit = '0;
    top_bit[N-1] = 1'b1;
    // R8 single product lands only in the top two words
    run_op(top_bit, top_bit, "top_bits", 1'b0);
    run_op({{(N-1){1'b0}}, 1'b1}, '1, "unit_times_ones", 1'b0);
    // R6 extra start mid-operation must be ignored
    run_op('1, rand_op(), "mid_start", 1'b1);
    for (int r = 0; r < 8; r++)
      run_op(rand_op(), rand_op(), $sformatf("rand%0d", r), 1'b0);
    // R9 back-to-back random after random
    run_op('0, rand_op(), "zero_a", 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule